// File: doc/BRIEF.md
# Dual Compare/Capture Timer

A 16-bit free-running counter with two output-compare channels, two input-capture channels and a wrap detector, reached through a byte-wide register port. The counter advances on each cycle in which the `tick` enable is high. Each compare channel owns a 16-bit match value and an output latch that drives a pin. Each capture channel records the counter value when its input shows the selected edge. A single interrupt line combines the flag groups, and each group has its own enable.

Software writes the match values and a control byte. The control byte holds a programmed pin level for each compare channel. On a real match, the channel copies its programmed level into its pin latch. A write-only force bit does the same copy at once, and it leaves the channel's compare flag untouched. Flags are read from a status byte and cleared by writing ones to them. Register reads are combinational from `bus_addr`. Writes take effect at the clock edge where `bus_wr` is high.

Register addresses: 0 control, 1 status, 2/3 counter high/low (read-only), 4/5 channel-1 match high/low, 6/7 channel-2 match high/low, 8/9 channel-1 capture high/low (read-only), 10/11 channel-2 capture high/low (read-only). Other addresses read zero.

Top module: `dual_timer`

## Requirements
- R1: After reset the control byte, status byte and counter all read zero, both compare pins are low and `irq` is low.
- R2: The counter increments by one at each clock edge where `tick` is high, and holds its value when `tick` is low.
- R3: When the counter steps from 0xFFFF to 0x0000, the wrap flag (status bit 3) is set.
- R4: When the counter steps onto a channel's match value, that channel's compare flag is set (status bit 5 for channel 1, bit 4 for channel 2). At the same edge the channel's level bit (control bit 0 for channel 1, bit 2 for channel 2) is copied to its pin latch. The pin then holds that value until the next match or force.
- R5: Writing a control byte with a force bit set (bit 3 for channel 1, bit 4 for channel 2) loads that channel's pin latch with the level bit written in the same byte. Force bits always read as zero, and a force leaves the compare flags unchanged.
- R6: Control bit 1 selects the capture edge for both channels (1 = rising, 0 = falling). A selected edge on a capture input copies the counter into that channel's capture register and sets its flag (status bit 7 for channel 1, bit 6 for channel 2). The opposite edge changes neither.
- R7: Writing the status byte clears each flag whose bit is written as one and leaves the others. Status bits 2..0 always read zero.
- R8: `irq` is high when the wrap flag and control bit 5 are both set, or when a compare flag and control bit 6 are both set, or when a capture flag and control bit 7 are both set. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counter advance enable |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| cap1_in | input | 1 | Capture input, channel 1 |
| cap2_in | input | 1 | Capture input, channel 2 |
| cmp1_pin | output | 1 | Compare output, channel 1 |
| cmp2_pin | output | 1 | Compare output, channel 2 |
| irq | output | 1 | Combined interrupt request |

## Verification
Compare matches are driven at two different match values with the level bits set high. This shows which channel's flag and pin react, and confirms that a pin holds its value while the counter passes non-matching values. Forces are applied with both low and high levels, including both channels in one write, to separate the latch path from the flag path and from the stored control bits. Captures are run in rising mode and in falling mode, each with the opposite edge also applied, so that edge selection and channel identity are told apart. A full count to 0xFFFF and one step further isolates the wrap flag and its interrupt enable from the compare flags.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int NUM_CH = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    localparam addr_t A_CTRL     = 4'd0;
    localparam addr_t A_STAT     = 4'd1;
    localparam addr_t A_CNT_HI   = 4'd2;
    localparam addr_t A_CNT_LO   = 4'd3;
    localparam addr_t A_CMP_BASE = 4'd4;
    localparam addr_t A_CAP_BASE = 4'd8;

    localparam int C_EDGE_RISE = 1;
    localparam int C_FORCE0    = 3;
    localparam int C_WRAP_EN   = 5;
    localparam int C_CMP_EN    = 6;
    localparam int C_CAP_EN    = 7;

    localparam int S_CAP0 = 7;
    localparam int S_CMP0 = 5;
    localparam int S_WRAP = 3;
endpackage

// File: rtl/timer_counter.sv
module timer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr_wrap,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_flag
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] TOPV = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             wrap;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_wrap) st_d.wrap = 1'b0;
        if (tick) begin
            st_d.cnt = st_q.cnt + ONE;
            if (st_q.cnt == TOPV) st_d.wrap = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt       = st_q.cnt;
    assign wrap_flag = st_q.wrap;

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == TOPV) |=> (wrap_flag && cnt == '0)); // R3
    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt)); // R2
endmodule

// File: rtl/timer_compare.sv
module timer_compare #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [7:0]       wdata,
    input  logic             level,
    input  logic             force_ld,
    input  logic             force_level,
    input  logic             clr_flag,
    output logic [CNT_W-1:0] match_val,
    output logic             flag,
    output logic             pin
);
    localparam int HI_W = CNT_W - 8;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] mval;
        logic             flag;
        logic             pin;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        st_d = st_q;
        hit  = tick && ((cnt + ONE) == st_q.mval);
        if (wr_hi) st_d.mval[CNT_W-1:8] = wdata[HI_W-1:0];
        if (wr_lo) st_d.mval[7:0]       = wdata;
        if (clr_flag) st_d.flag = 1'b0;
        if (hit) begin
            st_d.flag = 1'b1;
            st_d.pin  = level;
        end
        if (force_ld) st_d.pin = force_level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign match_val = st_q.mval;
    assign flag      = st_q.flag;
    assign pin       = st_q.pin;

    AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag); // R4
    AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !force_ld) |=> $stable(pin)); // R4
    AST_FORCE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (force_ld && !hit && !clr_flag) |=> $stable(flag)); // R5
    AST_FORCE_LOADS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        force_ld |=> (pin == $past(force_level))); // R5
endmodule

// File: rtl/timer_capture.sv
module timer_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             sig_in,
    input  logic             rise_sel,
    input  logic             clr_flag,
    output logic [CNT_W-1:0] cap_val,
    output logic             flag
);
    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cap;
        logic             flag;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       seen;

    always_comb begin
        st_d      = st_q;
        seen      = rise_sel ? (sig_in && !st_q.prev) : (!sig_in && st_q.prev);
        st_d.prev = sig_in;
        if (clr_flag) st_d.flag = 1'b0;
        if (seen) begin
            st_d.cap  = cnt;
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_val = st_q.cap;
    assign flag    = st_q.flag;

    AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        seen |=> (flag && cap_val == $past(cnt))); // R6
    AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |=> $stable(cap_val)); // R6
endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import dual_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cap1_in,
    input  logic              cap2_in,
    output logic              cmp1_pin,
    output logic              cmp2_pin,
    output logic              irq
);
    typedef struct packed {
        byte_t ctrl;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              wr_ctrl, wr_stat;
    logic [CNT_W-1:0]  cnt;
    logic              wrap_flag;
    logic [NUM_CH-1:0] ocf, icf, pins, cap_sig;
    logic [CNT_W-1:0]  mval [NUM_CH];
    logic [CNT_W-1:0]  cval [NUM_CH];
    byte_t             status;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_stat = bus_wr && (bus_addr == A_STAT);
    assign cap_sig = {cap2_in, cap1_in};

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ctrl = bus_wdata;
            for (int k = 0; k < NUM_CH; k++) st_d.ctrl[C_FORCE0+k] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .clr_wrap  (wr_stat && bus_wdata[S_WRAP]),
        .cnt       (cnt),
        .wrap_flag (wrap_flag)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam addr_t CMP_HI  = A_CMP_BASE + addr_t'(2 * g);
        localparam addr_t CAP_HI  = A_CAP_BASE + addr_t'(2 * g);
        localparam int    LVL_BIT = 2 * g;

        timer_compare #(.CNT_W(CNT_W)) u_cmp (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick        (tick),
            .cnt         (cnt),
            .wr_hi       (bus_wr && bus_addr == CMP_HI),
            .wr_lo       (bus_wr && bus_addr == CMP_HI + addr_t'(1)),
            .wdata       (bus_wdata),
            .level       (st_q.ctrl[LVL_BIT]),
            .force_ld    (wr_ctrl && bus_wdata[C_FORCE0+g]),
            .force_level (bus_wdata[LVL_BIT]),
            .clr_flag    (wr_stat && bus_wdata[S_CMP0-g]),
            .match_val   (mval[g]),
            .flag        (ocf[g]),
            .pin         (pins[g])
        );

        timer_capture #(.CNT_W(CNT_W)) u_cap (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt      (cnt),
            .sig_in   (cap_sig[g]),
            .rise_sel (st_q.ctrl[C_EDGE_RISE]),
            .clr_flag (wr_stat && bus_wdata[S_CAP0-g]),
            .cap_val  (cval[g]),
            .flag     (icf[g])
        );

        always_comb begin
            status[S_CAP0-g] = icf[g];
            status[S_CMP0-g] = ocf[g];
        end
    end

    always_comb begin
        status[S_WRAP] = wrap_flag;
        status[2:0]    = '0;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:   bus_rdata = st_q.ctrl;
            A_STAT:   bus_rdata = status;
            A_CNT_HI: bus_rdata = byte_t'(cnt >> 8);
            A_CNT_LO: bus_rdata = cnt[7:0];
            default: begin
                for (int k = 0; k < NUM_CH; k++) begin
                    if (bus_addr == A_CMP_BASE + addr_t'(2*k))     bus_rdata = byte_t'(mval[k] >> 8);
                    if (bus_addr == A_CMP_BASE + addr_t'(2*k + 1)) bus_rdata = mval[k][7:0];
                    if (bus_addr == A_CAP_BASE + addr_t'(2*k))     bus_rdata = byte_t'(cval[k] >> 8);
                    if (bus_addr == A_CAP_BASE + addr_t'(2*k + 1)) bus_rdata = cval[k][7:0];
                end
            end
        endcase
    end

    assign irq = (wrap_flag && st_q.ctrl[C_WRAP_EN])
              || ((|ocf) && st_q.ctrl[C_CMP_EN])
              || ((|icf) && st_q.ctrl[C_CAP_EN]);
    assign cmp1_pin = pins[0];
    assign cmp2_pin = pins[1];

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_q.ctrl[C_CAP_EN:C_WRAP_EN] != 3'b000)); // R8
    AST_WRITE_CLEARS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[C_CAP_EN:C_WRAP_EN] == 3'b000) |=> !irq); // R8
endmodule

// File: tb/dual_timer_bench.sv
`timescale 1ns/1ps
module dual_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cap1_in = 1'b0;
    logic       cap2_in = 1'b0;
    logic       cmp1_pin, cmp2_pin, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dual_timer u_dual_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap1_in(cap1_in), .cap2_in(cap2_in), .cmp1_pin(cmp1_pin),
        .cmp2_pin(cmp2_pin), .irq(irq)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic rd16(input logic [3:0] a, output int v);
        logic [7:0] h, l;
        rd(a, h);
        rd(a + 4'd1, l);
        v = {h, l};
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] b;
        int v;
        rd(4'd0, b);   check("R1", "ctrl", b, 0);
        rd(4'd1, b);   check("R1", "status", b, 0);
        rd16(4'd2, v); check("R1", "counter", v, 0);
        check("R1", "pins", {cmp2_pin, cmp1_pin}, 0);
        check("R1", "irq", irq, 0);
    endtask

    task automatic t_count;
        int v;
        run_ticks(10);
        rd16(4'd2, v); check("R2", "count after 10 ticks", v, 10);
        idle(5);
        rd16(4'd2, v); check("R2", "count holds without tick", v, 10);
    endtask

    task automatic t_compare;
        logic [7:0] b;
        wr(4'd4, 8'h00); wr(4'd5, 8'h14);
        wr(4'd6, 8'h00); wr(4'd7, 8'h1E);
        wr(4'd0, 8'h05);
        run_ticks(5);
        check("R4", "pin1 before match", cmp1_pin, 0);
        run_ticks(5);
        rd(4'd1, b); check("R4", "status at match 1", b, 8'h20);
        check("R4", "pins at match 1", {cmp2_pin, cmp1_pin}, 2'b01);
        check("R8", "irq with compare disabled", irq, 0);
        wr(4'd0, 8'h45);
        check("R8", "irq with compare enabled", irq, 1);
        run_ticks(10);
        rd(4'd1, b); check("R4", "status at match 2", b, 8'h30);
        check("R4", "pins at match 2", {cmp2_pin, cmp1_pin}, 2'b11);
    endtask

    task automatic t_clear;
        logic [7:0] b;
        wr(4'd1, 8'h07);
        rd(4'd1, b); check("R7", "zero bits leave flags", b, 8'h30);
        wr(4'd1, 8'h20);
        rd(4'd1, b); check("R7", "clear compare 1 only", b, 8'h10);
        wr(4'd1, 8'h10);
        rd(4'd1, b); check("R7", "all clear", b, 8'h00);
        check("R8", "irq after clear", irq, 0);
    endtask

    task automatic t_force;
        logic [7:0] b;
        wr(4'd0, 8'h48);
        check("R5", "force ch1 low", {cmp2_pin, cmp1_pin}, 2'b10);
        rd(4'd0, b); check("R5", "force bits read zero", b, 8'h40);
        rd(4'd1, b); check("R5", "force leaves flags", b, 8'h00);
        wr(4'd0, 8'h50);
        check("R5", "force ch2 low", {cmp2_pin, cmp1_pin}, 2'b00);
        wr(4'd0, 8'h1D);
        check("R5", "force both high", {cmp2_pin, cmp1_pin}, 2'b11);
        rd(4'd0, b); check("R5", "ctrl after double force", b, 8'h05);
        rd(4'd1, b); check("R5", "flags after double force", b, 8'h00);
        check("R8", "irq after force", irq, 0);
    endtask

    task automatic t_capture;
        logic [7:0] b;
        int v;
        wr(4'd0, 8'h82);
        cap1_in = 1'b1; idle(2);
        rd(4'd1, b);   check("R6", "rising edge sets flag 1", b, 8'h80);
        rd16(4'd8, v); check("R6", "capture 1 value", v, 30);
        check("R8", "irq on capture", irq, 1);
        run_ticks(5);
        cap1_in = 1'b0; idle(2);
        rd16(4'd8, v); check("R6", "falling edge ignored in rising mode", v, 30);
        wr(4'd1, 8'h80);
        wr(4'd0, 8'h80);
        run_ticks(5);
        cap2_in = 1'b1; idle(2);
        rd(4'd1, b); check("R6", "rising ignored in falling mode", b, 8'h00);
        cap2_in = 1'b0; idle(2);
        rd(4'd1, b);    check("R6", "falling edge sets flag 2", b, 8'h40);
        rd16(4'd10, v); check("R6", "capture 2 value", v, 40);
        rd16(4'd8, v);  check("R6", "capture 1 untouched", v, 30);
        wr(4'd1, 8'h40);
    endtask

    task automatic t_wrap;
        logic [7:0] b;
        int v;
        wr(4'd0, 8'h20);
        run_ticks(65535 - 40);
        rd16(4'd2, v); check("R3", "counter at top", v, 16'hFFFF);
        rd(4'd1, b);   check("R3", "no wrap yet", b, 8'h00);
        check("R8", "irq before wrap", irq, 0);
        run_ticks(1);
        rd16(4'd2, v); check("R3", "counter wrapped", v, 0);
        rd(4'd1, b);   check("R3", "wrap flag set", b, 8'h08);
        check("R8", "irq on wrap", irq, 1);
        wr(4'd0, 8'h00);
        check("R8", "irq masked", irq, 0);
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_count();
        t_compare();
        t_clear();
        t_force();
        t_capture();
        t_wrap();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            report();
        end
    end
endmodule